// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an SPI master read and write a bank of 24-bit registers with one fixed 32-bit frame per access. The master raises an active-high chip select and clocks the frame in SPI mode 0, most significant bit first. The leading bit says whether the frame writes or reads. The next six bits select one of 64 addresses. A reserved bit follows, and the last 24 bits carry the payload. The slave returns the addressed register's contents in the low 24 bits of the word it shifts out during that same frame, so a read needs no second frame.

The SPI pins are brought into the system clock domain through short synchronizers, and all frame handling runs on the system clock. Neighbouring logic sees a one-cycle read strobe as soon as a read frame's address is known, and a one-cycle write strobe with address and data once a write frame completes. Only the first `NUM_REGS` addresses hold storage. The rest read as zero, but a write to them is still announced on the strobe outputs.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 32 SCLK rising edges while chip select is high, sampled in mode 0, MSB first. Frame bit 31 is the write flag (1 = write, 0 = read), bits 30:25 the address, bit 24 reserved, bits 23:0 data. SCLK high and low phases each last at least 4 system clock periods.
- R2: For a complete write frame, a one-cycle `reg_wr_stb` appears carrying the frame address on `reg_addr` and frame bits 23:0 on `reg_wdata`, and an implemented register then holds that data.
- R3: During every complete frame, MISO bits 23:0 (as sampled by the master on rising edges) equal the addressed register's value from before the frame, and MISO bits 31:25 are 0.
- R4: A read frame gives one one-cycle `reg_rd_stb` with its address on `reg_addr` once the seventh bit has arrived. A write frame gives no read strobe.
- R5: Reserved frame bit 24 is ignored on input, and MISO bit 24 is always 0.
- R6: If chip select drops before the 32nd rising edge, no write strobe occurs, no register changes, and the next frame decodes from its first bit.
- R7: A 32nd rising edge that reaches the synchronizers in the same system cycle as the fall of chip select is discarded, so the frame counts as aborted under R6.
- R8: Addresses at or above `NUM_REGS` (default 40) read as 0, and writes to them change no register. Their strobes are still given.
- R9: Rising edges after the 32nd within one chip-select window are ignored: no second strobe and no register change.
- R10: After reset all registers are 0, both strobes are low, and MISO is 0. MISO is 0 whenever chip select is low.
- R11: `reg_wr_stb` and `reg_rd_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| reg_wr_stb | output | 1 | One-cycle write notification |
| reg_rd_stb | output | 1 | One-cycle read notification |
| reg_addr | output | 6 | Address belonging to the active strobe |
| reg_wdata | output | 24 | Write data belonging to the write strobe |

## Verification
Two events can land in the same system cycle: the last rising SCLK edge of a frame and the fall of chip select. Because both pins pass through synchronizers of equal depth, the bench provokes this by raising SCLK and lowering chip select at the same instant on the 32nd bit. The result is judged at the ports. No write strobe may appear, and a following read frame must return the register's earlier value. A per-clock monitor checks every strobe against a queue of events predicted by a behavioural register model, so a stray or missing strobe is caught in the cycle it happens.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int FRAME_W  = 32;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 24;
    localparam int HDR_BITS = 1 + ADDR_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    // Frame layout; neighbours decode these positions, so the order is fixed.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic              rsvd;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              wr_stb;
        logic              rd_stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    // Reply word shifted left so that, after the next falling edge,
    // the reserved position sits at the shift register's top bit.
    function automatic logic [FRAME_W-1:0] reply_load(input logic [DATA_W-1:0] v);
        frame_t w;
        w      = '0;
        w.data = v;
        return FRAME_W'(w) << (HDR_BITS - 1);
    endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_value,
    output logic              miso,
    output reg_req_t          req
);
    logic               sclk_q;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx;
    logic [FRAME_W-1:0] tx;
    logic               hdr_done;
    logic               frm_done;
    logic               rise, fall;
    frame_t             rx_f;

    assign rise = cs_s &  sclk_s & ~sclk_q;
    assign fall = cs_s & ~sclk_s &  sclk_q;
    assign rx_f = frame_t'(rx);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cnt      <= '0;
            rx       <= '0;
            tx       <= '0;
            hdr_done <= 1'b0;
            frm_done <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            hdr_done <= 1'b0;
            frm_done <= 1'b0;
            if (!cs_s) begin
                cnt <= '0;
                tx  <= '0;
            end else begin
                if (rise && cnt < CNT_W'(FRAME_W)) begin
                    rx  <= {rx[FRAME_W-2:0], mosi_s};
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(HDR_BITS - 1)) hdr_done <= 1'b1;
                    if (cnt == CNT_W'(FRAME_W - 1))  frm_done <= 1'b1;
                end
                if (hdr_done)
                    tx <= reply_load(rd_value);
                else if (fall)
                    tx <= tx << 1;
            end
        end
    end

    assign miso       = cs_s & tx[FRAME_W-1];
    assign req.wr_stb = frm_done & rx_f.wr;
    assign req.rd_stb = hdr_done & ~rx[HDR_BITS-1];
    assign req.addr   = hdr_done ? rx[ADDR_W-1:0] : rx_f.addr;
    assign req.wdata  = rx_f.data;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W));
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> (cnt == '0));
    p_wr_single_r2: assert property (@(posedge clk) disable iff (rst)
        req.wr_stb |=> !req.wr_stb);
    p_rd_single_r4: assert property (@(posedge clk) disable iff (rst)
        req.rd_stb |=> !req.rd_stb);
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(req.wr_stb && req.rd_stb));
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
    import spireg_pkg::*;
#(
    parameter int NUM_REGS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    output logic [DATA_W-1:0] rd_value
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (req.wr_stb && req.addr == ADDR_W'(g))
                regs[g] <= req.wdata;
        end

        p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
            (req.wr_stb && req.addr == ADDR_W'(g)) |=> regs[g] == $past(req.wdata));
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (req.addr == ADDR_W'(i)) rd_value = regs[i];
    end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spireg_pkg::*;
#(
    parameter int NUM_REGS    = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              reg_wr_stb,
    output logic              reg_rd_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    logic [2:0]        pins_s;
    reg_req_t          req;
    logic [DATA_W-1:0] rd_value;

    spireg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs, spi_mosi}),
        .q   (pins_s)
    );

    spireg_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (pins_s[2]),
        .cs_s     (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .rd_value (rd_value),
        .miso     (spi_miso),
        .req      (req)
    );

    spireg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd_value (rd_value)
    );

    assign reg_wr_stb = req.wr_stb;
    assign reg_rd_stb = req.rd_stb;
    assign reg_addr   = req.addr;
    assign reg_wdata  = req.wdata;

    p_miso_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !pins_s[1] |-> !spi_miso);
    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (req.addr >= ADDR_W'(NUM_REGS)) |-> rd_value == '0);
endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
    localparam int NREG = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
    logic        miso, wr_stb, rd_stb;
    logic [5:0]  addr;
    logic [23:0] wdata;

    int total = 0;
    int fails = 0;
    int model [64];

    typedef struct {
        bit    wr;
        int    a;
        int    d;
        string tag;
    } ev_t;
    ev_t evq[$];

    spi_reg_slave #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs(cs), .spi_mosi(mosi),
        .spi_miso(miso), .reg_wr_stb(wr_stb), .reg_rd_stb(rd_stb),
        .reg_addr(addr), .reg_wdata(wdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Per-clock monitor against predicted strobe events.
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb && rd_stb) chk(1'b0, "R11 both strobes", 32'd1, 32'd0);
            if (wr_stb || rd_stb) begin
                if (evq.size() == 0) begin
                    chk(1'b0, "R9 unexpected strobe", {26'd0, addr}, 32'hFFFFFFFF);
                end else begin
                    ev_t e;
                    e = evq.pop_front();
                    chk(wr_stb == e.wr, {e.tag, " strobe kind"}, {31'd0, wr_stb}, {31'd0, e.wr});
                    chk(addr == 6'(e.a), {e.tag, " strobe addr"}, {26'd0, addr}, e.a);
                    if (e.wr) chk(wdata == 24'(e.d), {e.tag, " strobe data"}, {8'd0, wdata}, e.d);
                end
            end
        end
    end

    task automatic xfer(input logic [31:0] w, input int nbits, input bit coincide, output logic [31:0] got);
        got = '0;
        cs = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? w[31-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i < 32) got[31-i] = miso;
            if (coincide && i == nbits - 1) begin
                sclk = 1'b1;
                cs   = 1'b0;
            end else begin
                sclk = 1'b1;
                repeat (4) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (4) @(negedge clk);
        cs = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input bit wr, input int a, input int d, input bit rsvd,
                         input int nbits, input bit coincide, input string tag);
        logic [31:0] w, got;
        int  old;
        bit  complete;
        ev_t e;
        w        = {wr, 6'(a), rsvd, 24'(d)};
        old      = (a < NREG) ? model[a] : 0;
        complete = (nbits >= 32) && !coincide;
        if (!wr && nbits >= 7) begin
            e = '{wr: 1'b0, a: a, d: 0, tag: tag};
            evq.push_back(e);
        end
        if (wr && complete) begin
            e = '{wr: 1'b1, a: a, d: d & 24'hFFFFFF, tag: tag};
            evq.push_back(e);
        end
        xfer(w, nbits, coincide, got);
        if (complete) begin
            chk(got == {8'd0, 24'(old)}, {tag, " miso word"}, got, {8'd0, 24'(old)});
            chk(got[24] == 1'b0, "R5 miso reserved bit", {31'd0, got[24]}, 32'd0);
        end
        chk(evq.size() == 0, {tag, " strobes outstanding"}, evq.size(), 0);
        evq.delete();
        if (wr && complete && a < NREG) model[a] = d & 24'hFFFFFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        foreach (model[i]) model[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(miso == 1'b0, "R10 miso after reset", {31'd0, miso}, 32'd0);
        chk(!wr_stb && !rd_stb, "R10 strobes after reset", {30'd0, wr_stb, rd_stb}, 32'd0);

        // R1 R3 R4: read of a reset register
        frame(1'b0, 5, 0, 1'b0, 32, 1'b0, "R4 read");
        // R2: write then read back
        frame(1'b1, 5, 24'hA5C3E1, 1'b0, 32, 1'b0, "R2 write");
        frame(1'b0, 5, 0, 1'b0, 32, 1'b0, "R3 readback");
        // R8: unimplemented address
        frame(1'b1, 63, 24'h123456, 1'b0, 32, 1'b0, "R8 write unimpl");
        frame(1'b0, 63, 0, 1'b0, 32, 1'b0, "R8 read unimpl");
        frame(1'b0, NREG, 0, 1'b0, 32, 1'b0, "R8 read first unimpl");
        // R5: reserved bit set on input
        frame(1'b1, 0, 24'hFFFFFF, 1'b1, 32, 1'b0, "R5 write rsvd");
        frame(1'b0, 0, 0, 1'b1, 32, 1'b0, "R5 read rsvd");
        // boundary: last implemented register
        frame(1'b1, NREG - 1, 24'h5A5A5A, 1'b0, 32, 1'b0, "R2 write top");
        frame(1'b0, NREG - 1, 0, 1'b0, 32, 1'b0, "R3 read top");
        // R6: aborted write, then aborted read before header complete
        frame(1'b1, 5, 24'h000111, 1'b0, 16, 1'b0, "R6 abort write");
        frame(1'b0, 5, 0, 1'b0, 4, 1'b0, "R6 abort short");
        frame(1'b0, 5, 0, 1'b0, 32, 1'b0, "R6 after abort");
        // R7: last edge and chip-select fall together
        frame(1'b1, 5, 24'h0BEEF0, 1'b0, 32, 1'b1, "R7 coincide");
        frame(1'b0, 5, 0, 1'b0, 32, 1'b0, "R7 after coincide");
        // R9: extra clocks after the frame
        frame(1'b1, 7, 24'h777777, 1'b0, 40, 1'b0, "R9 long write");
        frame(1'b0, 7, 0, 1'b0, 40, 1'b0, "R9 long read");
        // R2 R3 several patterns
        for (int k = 0; k < 12; k++) begin
            int a, d;
            a = (k * 7 + 3) % 64;
            d = (24'h13579B ^ (k * 24'h0F1E2D)) & 24'hFFFFFF;
            frame(1'b1, a, d, k[0], 32, 1'b0, "R2 pattern write");
            frame(1'b0, a, 0, 1'b0, 32, 1'b0, "R3 pattern read");
        end
        frame(1'b0, 5, 0, 1'b0, 32, 1'b0, "R3 final");

        // R10: miso low with chip select low
        chk(miso == 1'b0, "R10 miso idle", {31'd0, miso}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule